// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous system bus and an asynchronous static RAM with 17 address bits and an 8-bit bidirectional data bus. A single-word read or write request is taken in one cycle. The controller latches the address and write data, then drives the RAM's active-low chip-enable, output-enable and write-enable strobes through a fixed sequence of phases. Each phase lasts a number of clock cycles set by a parameter: nanosecond minima are rounded up at the system clock period.

A read holds output-enable low long enough for the access time, samples the data bus at the end of that window, and then releases the RAM. A write pulls write-enable low and waits a turnaround interval before the data driver switches on, because the RAM needs time to let go of the bus. It then raises write-enable to end the write window while address and data are still held.

Every access ends with a deselect gap in which all strobes are high. That gap is also the bus turnaround between a read and any following write. A one-cycle done pulse marks completion, and busy covers the whole access.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, ce_n, oe_n and we_n are 1, dq_oe is 0, and busy and done are 0.
- R2: A request (req=1) seen on a clock edge while busy is 0 is accepted. busy is 1 from the next cycle until the cycle that done is 1.
- R3: On a read (we_req=0), ce_n goes low one cycle before oe_n does. oe_n then stays low for exactly T_AA cycles. The byte on dq_in at the end of that window appears on rdata when done is 1.
- R4: On a write (we_req=1), we_n stays low for exactly max(T_PWE, T_TURN+T_SD) cycles while ce_n is low and oe_n is high. dq_oe rises only after we_n has been low for T_TURN cycles, and stays 1 until we_n rises. The RAM then holds the written byte at that address.
- R5: dq_oe is never 1 while oe_n is 0. oe_n and we_n are never low together. we_n is low only while ce_n is low.
- R6: After every access, ce_n, oe_n and we_n all stay high for at least T_REL cycles before ce_n falls again. sram_addr does not change while ce_n stays low.
- R7: done is high for exactly one cycle per access. It comes 1+T_AA+T_REL cycles after a read is accepted and 1+max(T_PWE,T_TURN+T_SD)+T_REL cycles after a write is accepted. rdata changes only when a read completes.
- R8: A request presented while busy is 1 is ignored. It produces no done pulse and does not change RAM contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Access request, taken when busy is 0 |
| we_req | input | 1 | 1 selects write, 0 selects read |
| addr | input | 17 | Word address of the request |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Access in progress |
| ce_n | output | 1 | RAM chip-enable, active low |
| oe_n | output | 1 | RAM output-enable, active low |
| we_n | output | 1 | RAM write-enable, active low |
| sram_addr | output | 17 | RAM address pins |
| dq_out | output | 8 | Data to drive onto the RAM bus |
| dq_oe | output | 1 | Enable for the data bus driver |
| dq_in | input | 8 | Data sampled from the RAM bus |

## Verification
A wrong phase counter shows within the same access, as an output-enable or write-enable pulse of the wrong length and a done pulse on the wrong cycle. A wrong state decode shows on the first cycle that it is reached. In that case the driver overlaps output-enable, or the strobes stay low while busy is 0. Corrupted latched address or data stays hidden until that location is read back, so every write is followed at some point by a read of the same address, including the lowest and highest addresses.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_RDWAIT  = 3'd2,
    ST_WRPULSE = 3'd3,
    ST_RELEASE = 3'd4
  } ctlState_e;

  // Strobes from control to datapath; RAM strobes are registered, the
  // last three are single-cycle event markers.
  typedef struct packed {
    logic ceN;
    logic oeN;
    logic weN;
    logic drive;
    logic load;
    logic capture;
    logic fin;
  } ctlStrb_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_ctrl.sv
module sram_ctl_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int T_AA   = 2,
  parameter int T_PWE  = 2,
  parameter int T_TURN = 1,
  parameter int T_SD   = 2,
  parameter int T_REL  = 1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     req,
  input  logic     weReq,
  output ctlStrb_t strb,
  output logic     busy
);

  localparam int AA_EFF  = maxOf(T_AA, 1);
  localparam int REL_EFF = maxOf(T_REL, 1);
  localparam int PWE_EFF = maxOf(maxOf(T_PWE, T_TURN + T_SD), 1);
  localparam int CNT_MAX = maxOf(maxOf(AA_EFF, REL_EFF), PWE_EFF);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] AA_LAST  = CNT_W'(AA_EFF - 1);
  localparam logic [CNT_W-1:0] PWE_LAST = CNT_W'(PWE_EFF - 1);
  localparam logic [CNT_W-1:0] REL_LAST = CNT_W'(REL_EFF - 1);
  localparam logic [CNT_W-1:0] TURN_C   = CNT_W'(T_TURN);

  ctlState_e        state, stateNxt;
  logic [CNT_W-1:0] phaseCnt, phaseCntNxt;
  logic             isWrite;
  logic             accept;
  logic             ceNQ, oeNQ, weNQ, driveQ;

  assign accept = req && (state == ST_IDLE);

  always_comb begin
    stateNxt    = state;
    phaseCntNxt = phaseCnt;
    case (state)
      ST_IDLE: begin
        phaseCntNxt = '0;
        if (accept) stateNxt = ST_SETUP;
      end
      ST_SETUP: begin
        phaseCntNxt = '0;
        stateNxt    = isWrite ? ST_WRPULSE : ST_RDWAIT;
      end
      ST_RDWAIT: begin
        if (phaseCnt == AA_LAST) begin
          stateNxt    = ST_RELEASE;
          phaseCntNxt = '0;
        end else begin
          phaseCntNxt = phaseCnt + 1'b1;
        end
      end
      ST_WRPULSE: begin
        if (phaseCnt == PWE_LAST) begin
          stateNxt    = ST_RELEASE;
          phaseCntNxt = '0;
        end else begin
          phaseCntNxt = phaseCnt + 1'b1;
        end
      end
      ST_RELEASE: begin
        if (phaseCnt == REL_LAST) begin
          stateNxt    = ST_IDLE;
          phaseCntNxt = '0;
        end else begin
          phaseCntNxt = phaseCnt + 1'b1;
        end
      end
      default: begin
        stateNxt    = ST_IDLE;
        phaseCntNxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      isWrite  <= 1'b0;
      ceNQ     <= 1'b1;
      oeNQ     <= 1'b1;
      weNQ     <= 1'b1;
      driveQ   <= 1'b0;
    end else begin
      state    <= stateNxt;
      phaseCnt <= phaseCntNxt;
      if (accept) isWrite <= weReq;
      ceNQ   <= !((stateNxt == ST_SETUP) || (stateNxt == ST_RDWAIT) ||
                  (stateNxt == ST_WRPULSE));
      oeNQ   <= !(stateNxt == ST_RDWAIT);
      weNQ   <= !(stateNxt == ST_WRPULSE);
      driveQ <= (stateNxt == ST_WRPULSE) && (phaseCntNxt >= TURN_C);
    end
  end

  assign busy         = (state != ST_IDLE);
  assign strb.ceN     = ceNQ;
  assign strb.oeN     = oeNQ;
  assign strb.weN     = weNQ;
  assign strb.drive   = driveQ;
  assign strb.load    = accept;
  assign strb.capture = (state == ST_RDWAIT) && (phaseCnt == AA_LAST);
  assign strb.fin     = (state == ST_RELEASE) && (phaseCnt == REL_LAST);

  // Independent run-length counters used only by the checks below.
  logic [CNT_W:0] weLowRun, oeLowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowRun <= '0;
      oeLowRun <= '0;
    end else begin
      weLowRun <= weNQ ? '0 : weLowRun + 1'b1;
      oeLowRun <= oeNQ ? '0 : oeLowRun + 1'b1;
    end
  end

  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weNQ) |-> (weLowRun == (CNT_W+1)'(PWE_EFF))) else $error("we_n width"); // R4
  AST_OE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeNQ) |-> (oeLowRun == (CNT_W+1)'(AA_EFF))) else $error("oe_n width"); // R3
  AST_DRIVE_TURN: assert property (@(posedge clk) disable iff (!rstN)
    driveQ |-> (!weNQ && (weLowRun >= (CNT_W+1)'(T_TURN)))) else $error("early drive"); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (ceNQ && oeNQ && weNQ && !driveQ)) else $error("strobe while idle"); // R6
  AST_OE_WE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeNQ && !weNQ)) else $error("oe and we both low"); // R5

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] wdataIn,
  input  logic [DATA_W-1:0] dqIn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] rdataOut,
  output logic              doneOut
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      if (strb.load) begin
        addrQ  <= addrIn;
        wdataQ <= wdataIn;
      end
      if (strb.capture) rdataQ <= dqIn;
      doneQ <= strb.fin;
    end
  end

  assign ramAddr  = addrQ;
  assign dqOut    = wdataQ;
  assign dqOe     = strb.drive;
  assign rdataOut = rdataQ;
  assign doneOut  = doneQ;

  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> strb.oeN) else $error("driver on while oe low"); // R5
  AST_WE_IN_CE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.weN |-> !strb.ceN) else $error("we low outside ce"); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ceN && $past(!strb.ceN)) |-> $stable(ramAddr)) else $error("addr moved"); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut) else $error("done too long"); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.capture) |-> $stable(rdataOut)) else $error("rdata moved"); // R7

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int T_AA   = 2,
  parameter int T_PWE  = 2,
  parameter int T_TURN = 1,
  parameter int T_SD   = 2,
  parameter int T_REL  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              busy,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  ctlStrb_t strb;

  sram_ctl_ctrl #(
    .T_AA(T_AA), .T_PWE(T_PWE), .T_TURN(T_TURN), .T_SD(T_SD), .T_REL(T_REL)
  ) u_ctrl (
    .clk(clk), .rstN(rst_n), .req(req), .weReq(we_req),
    .strb(strb), .busy(busy)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rst_n), .strb(strb),
    .addrIn(addr), .wdataIn(wdata), .dqIn(dq_in),
    .ramAddr(sram_addr), .dqOut(dq_out), .dqOe(dq_oe),
    .rdataOut(rdata), .doneOut(done)
  );

  assign ce_n = strb.ceN;
  assign oe_n = strb.oeN;
  assign we_n = strb.weN;

endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;

  localparam int AW = 17, DW = 8;
  localparam int T_AA = 2, T_PWE = 2, T_TURN = 1, T_SD = 2, T_REL = 1;
  localparam int PWE_X = (T_PWE > T_TURN + T_SD) ? T_PWE : T_TURN + T_SD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we_req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata, dq_out, dq_in;
  logic done, busy, ce_n, oe_n, we_n, dq_oe;
  logic [AW-1:0] sram_addr;

  int total = 0, bad = 0;
  logic [DW-1:0] ram [int];

  always #2.5 clk = ~clk;

  sram_ctl #(.T_AA(T_AA), .T_PWE(T_PWE), .T_TURN(T_TURN), .T_SD(T_SD), .T_REL(T_REL))
  u_dut (.*);

  function automatic logic [DW-1:0] fillOf(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {7'd0, a[16]};
  endfunction
  function automatic logic [DW-1:0] ramRead(input logic [AW-1:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : fillOf(a);
  endfunction
  function automatic int expLat(input logic w);
    return 1 + (w ? PWE_X : T_AA) + T_REL;
  endfunction

  // RAM model: drives the bus when selected for read.
  wire ramDrive = !ce_n && !oe_n && we_n;
  assign dq_in = ramDrive ? ramRead(sram_addr) : (dq_oe ? dq_out : 8'h00);

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // Strobe monitor and RAM write commit, away from the active edge.
  int weRun = 0, oeRun = 0, ceLowRun = 0, ceHighRun = 100;
  logic drvSeen = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (dq_oe && !oe_n) check(1'b0, "R5 bus fight", 1, 0);
    if (!oe_n && !we_n) check(1'b0, "R5 oe/we overlap", 1, 0);
    if (!we_n && ce_n) check(1'b0, "R5 we outside ce", 1, 0);
    if (!ce_n && ceHighRun > 0) begin
      check(ceHighRun >= T_REL, "R6 deselect gap", ceHighRun, T_REL);
      ceHighRun = 0;
    end
    if (!oe_n && oeRun == 0) check(ceLowRun == 1, "R3 ce before oe", ceLowRun, 1);
    if (oe_n && oeRun > 0) begin
      check(oeRun == T_AA, "R3 oe width", oeRun, T_AA);
      oeRun = 0;
    end
    if (!we_n && dq_oe && !drvSeen) begin
      check(weRun == T_TURN, "R4 turnaround", weRun, T_TURN);
      drvSeen = 1'b1;
    end
    if (we_n && weRun > 0) begin
      check(weRun == PWE_X, "R4 we width", weRun, PWE_X);
      weRun = 0;
      drvSeen = 1'b0;
    end
    if (!ce_n && !we_n && dq_oe) ram[int'(sram_addr)] = dq_out;
    if (!oe_n) oeRun++;
    if (!we_n) weRun++;
    if (ce_n) begin ceHighRun++; ceLowRun = 0; end else ceLowRun++;
  end

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic poke);
    logic [DW-1:0] oldR;
    logic [DW-1:0] pokeOld;
    int cyc;
    oldR = rdata;
    pokeOld = ramRead(a ^ 17'h00155);
    @(negedge clk);
    req = 1'b1; we_req = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    if (poke) begin
      req = 1'b1; we_req = 1'b1; addr = a ^ 17'h00155; wdata = ~d;
    end else req = 1'b0;
    cyc = 0;
    do begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end while (!done && cyc < 60);
    req = 1'b0;
    check(cyc == expLat(w), "R7 done latency", cyc, expLat(w));
    if (w) begin
      check(rdata == oldR, "R7 rdata held on write", rdata, oldR);
      check(ram.exists(int'(a)) && ram[int'(a)] == d, "R4 byte stored",
            ramRead(a), d);
    end else begin
      check(rdata == ramRead(a), "R3 read data", rdata, ramRead(a));
    end
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7 single done / R2 idle", done, 0);
    if (poke) check(ramRead(a ^ 17'h00155) == pokeOld, "R8 ignored request",
                    ramRead(a ^ 17'h00155), pokeOld);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [AW-1:0] pool [8];
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check(ce_n && oe_n && we_n && !dq_oe && !busy && !done, "R1 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ce_n && oe_n && we_n && !dq_oe && !busy && !done, "R1 after reset", done, 0);

    // directed corners: lowest and highest address, read of unwritten
    access(1'b0, 17'h00000, 8'h00, 1'b0);
    access(1'b1, 17'h00000, 8'hA5, 1'b0);
    access(1'b1, 17'h1FFFF, 8'h3C, 1'b0);
    access(1'b0, 17'h00000, 8'h00, 1'b0);
    access(1'b0, 17'h1FFFF, 8'h00, 1'b0);
    // write immediately after read at same address (turnaround)
    access(1'b1, 17'h1FFFF, 8'hFF, 1'b0);
    access(1'b0, 17'h1FFFF, 8'h00, 1'b0);
    // request held during busy must be ignored (R8)
    access(1'b0, 17'h00400, 8'h00, 1'b1);
    access(1'b1, 17'h00800, 8'h11, 1'b1);

    for (int i = 0; i < 8; i++) pool[i] = AW'($urandom);
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = pool[$urandom_range(7)];
      access(1'($urandom), a, DW'($urandom), ($urandom_range(9) == 0));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule